// File: doc/BRIEF.md
# FIFO-Buffered Pulse-Width Modulator

This block drives one pulse-width-modulated output from a small memory-mapped register set. Firmware selects a clock divider and a period, then queues duty values into a four-entry sample queue. A free-running counter paces each period. At the start of every period the generator takes the oldest queued duty value. When the queue is empty, it keeps the value it already holds. Firmware can therefore stream a sequence of duty values with one write per period, and it can read the queue occupancy so that it does not overrun the queue.

The register port uses 32-bit data and word addresses. Both the write port and the read port take a valid strobe and always report ready. The read data is combinational and is valid in the same cycle as the read strobe. The control word enables the generator, sets the divider and the polarity, stores the clock-select and low-power mode fields for readback, and carries a soft-reset bit that clears itself.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, every mapped register reads zero and `pwmOut` is 0.
- R2: Word 0 is the control register. It stores bit 0 (run), bits 15:4 (divider minus one), bits 17:16 (clock select), bit 18 (invert) and bits 25:22 (mode enables), and reads back exactly those bits. Every other bit reads 0, and bit 3 always reads 0.
- R3: A write to word 3 queues the low 16 bits as a duty sample. Status word 1, bits 2:0, gives the number of queued samples, from 0 to 4.
- R4: A sample write is dropped when 4 samples are queued, and the write sets status bit 4. Status bit 4 stays set until a reset or a soft reset clears it.
- R5: Word 4 holds a 16-bit period P. With the divider field F, one period lasts (P+2)·(F+1) clock cycles. The counter steps once every F+1 cycles and takes the values 0 to P+1.
- R6: Before polarity is applied, the output is active while the counter is below the current duty value D. A duty of 0 gives an output that is never active, and a duty of P+2 or more gives an output that is always active.
- R7: When the generator starts and at each period rollover, it pops the next queued sample into the current duty. If the queue is empty, it reuses the previous duty.
- R8: Control bit 18 inverts `pwmOut`. This holds both while running and while stopped.
- R9: One cycle after run is cleared, the output sits at the inactive level (which equals the invert bit), and the counter and divider hold at zero. A later start restarts the period from counter 0.
- R10: A control write with bit 3 set ignores the other bits of the written word. The write empties the queue, clears the overflow flag, returns every register and the current duty to zero, and stops the output at the following clock edge.
- R11: A read of word 3 returns the current duty value. Reads of words 2, 5, 6 and 7 return 0, and writes to those words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Register write strobe |
| wrReady | output | 1 | Write accepted (always 1) |
| wrAddr | input | 3 | Write word address |
| wrData | input | 32 | Write data |
| rdValid | input | 1 | Register read strobe |
| rdReady | output | 1 | Read accepted (always 1) |
| rdAddr | input | 3 | Read word address |
| rdData | output | 32 | Read data, same cycle as rdValid |
| pwmOut | output | 1 | Modulated output |

## Verification
The in-line properties check the following on every cycle:
- queue occupancy stays within its bound;
- the overflow flag is set by a write to a full queue and stays set;
- a soft reset empties the queue and clears the control word;
- the soft-reset bit always reads zero;
- a stopped generator keeps its counters at zero and its output at the inactive level;
- a zero duty keeps the output inactive;
- the counter returns to zero at a rollover.

Only the bench scenarios can show the waveform itself. These cover the exact period length for several divider and period values, the order in which queued duties are consumed, the reuse of the last duty when the queue is empty, the inverted waveform, and the register readback.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 12;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  // word addresses
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PER  = 3'd4;

  // control bit positions
  localparam int BIT_RUN  = 0;
  localparam int BIT_SWR  = 3;
  localparam int PRE_LSB  = 4;
  localparam int BIT_INV  = 18;
  localparam int STAT_OVF = 4;

  // stored control bits: run, divider, clock select, invert, mode enables
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h03C7_FFF1;

  typedef struct packed {
    logic             run;
    logic             invert;
    logic [PRE_W-1:0] preDiv;
    logic [CNT_W-1:0] period;
    logic             headValid;
    logic [CNT_W-1:0] head;
    logic             flush;
  } pwm_cmd_t;
endpackage

// File: rtl/pwm_regctl.sv
module pwm_regctl
  import pwm_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              pop,
  input  logic [CNT_W-1:0]  curDuty,
  output pwm_cmd_t          cmd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] ctrlQ;
  logic [CNT_W-1:0]  periodQ;
  logic [CNT_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [OCC_W-1:0]  occ;
  logic              ovfQ;

  logic wrCtrl, swrHit, push, accept, popOk;
  assign wrCtrl = wrValid && (wrAddr == ADDR_CTRL);
  assign swrHit = wrCtrl && wrData[BIT_SWR];
  assign push   = wrValid && (wrAddr == ADDR_DUTY);
  assign accept = push && (occ < OCC_W'(DEPTH));
  assign popOk  = pop && (occ != '0);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wrPtr] <= wrData[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || swrHit) begin
      ctrlQ   <= '0;
      periodQ <= '0;
      wrPtr   <= '0;
      rdPtr   <= '0;
      occ     <= '0;
      ovfQ    <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= wrData & CTRL_MASK;
      if (wrValid && wrAddr == ADDR_PER) periodQ <= wrData[CNT_W-1:0];
      if (accept) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({accept, popOk})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
      if (push && !accept) ovfQ <= 1'b1;
    end
  end

  logic [DATA_W-1:0] statWord;
  always_comb begin
    statWord = '0;
    statWord[OCC_W-1:0] = occ;
    statWord[STAT_OVF]  = ovfQ;
  end

  always_comb begin
    rdData = '0;
    if (rdValid) begin
      case (rdAddr)
        ADDR_CTRL: rdData = ctrlQ;
        ADDR_STAT: rdData = statWord;
        ADDR_DUTY: rdData = DATA_W'(curDuty);
        ADDR_PER:  rdData = DATA_W'(periodQ);
        default:   rdData = '0;
      endcase
    end
  end

  always_comb begin
    cmd.run       = ctrlQ[BIT_RUN];
    cmd.invert    = ctrlQ[BIT_INV];
    cmd.preDiv    = ctrlQ[PRE_LSB +: PRE_W];
    cmd.period    = periodQ;
    cmd.headValid = (occ != '0);
    cmd.head      = mem[rdPtr];
    cmd.flush     = swrHit;
  end

  // R3: occupancy never exceeds the queue depth
  p_occupancy_r3: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_W'(DEPTH));
  // R4: a write to a full queue is dropped and raises the flag
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    (push && occ == OCC_W'(DEPTH) && !pop) |=> (occ == OCC_W'(DEPTH) && ovfQ));
  // R4: the flag is sticky
  p_sticky_ovf_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovfQ && !swrHit) |=> ovfQ);
  // R10: soft reset clears the queue and the control word
  p_swr_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    swrHit |=> (occ == '0 && ctrlQ == '0 && !ovfQ));
  // R2: the soft-reset bit never reads back as one
  p_swr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdAddr == ADDR_CTRL) |-> !rdData[BIT_SWR]);
endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pwm_cmd_t         cmd,
  output logic             pop,
  output logic [CNT_W-1:0] curDuty,
  output logic             pwmOut
);
  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W:0]   cnt;
  logic [CNT_W-1:0] duty;

  logic           tick, wrap, load, active;
  logic [CNT_W:0] lastCnt;

  assign tick    = (preCnt >= cmd.preDiv);
  assign lastCnt = {1'b0, cmd.period} + (CNT_W + 1)'(1);
  assign wrap    = running && tick && (cnt >= lastCnt);
  assign load    = cmd.run && (!running || wrap);
  assign pop     = load && cmd.headValid && !cmd.flush;

  always_ff @(posedge clk) begin
    if (!rstN || cmd.flush) begin
      running <= 1'b0;
      preCnt  <= '0;
      cnt     <= '0;
      duty    <= '0;
    end else if (!cmd.run) begin
      running <= 1'b0;
      preCnt  <= '0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      preCnt  <= '0;
      cnt     <= '0;
      if (cmd.headValid) duty <= cmd.head;
    end else if (tick) begin
      preCnt <= '0;
      if (wrap) begin
        cnt <= '0;
        if (cmd.headValid) duty <= cmd.head;
      end else begin
        cnt <= cnt + (CNT_W + 1)'(1);
      end
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign active  = running && (cnt < {1'b0, duty});
  assign pwmOut  = active ^ cmd.invert;
  assign curDuty = duty;

  // R9: stopped generator keeps its counters at zero
  p_idle_counts_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (cnt == '0 && preCnt == '0));
  // R9: stopped generator sits at the inactive level
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (pwmOut == cmd.invert));
  // R6: zero duty never drives the active level
  p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (running && duty == '0) |-> (pwmOut == cmd.invert));
  // R5: a rollover restarts the counter
  p_wrap_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrap && cmd.run && !cmd.flush) |=> (cnt == '0));
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
  import pwm_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  pwm_cmd_t         cmd;
  logic             pop;
  logic [CNT_W-1:0] curDuty;

  assign wrReady = 1'b1;
  assign rdReady = 1'b1;

  pwm_regctl #(.DEPTH(DEPTH)) i_regctl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData),
    .pop(pop), .curDuty(curDuty), .cmd(cmd)
  );

  pwm_core i_core (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .pop(pop), .curDuty(curDuty), .pwmOut(pwmOut)
  );
endmodule

// File: tb/test_pwm_fifo_gen.sv
module test_pwm_fifo_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdValid = 1'b0;
  logic        rdReady;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        pwmOut;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pwm_fifo_gen i_pwm_fifo_gen (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr), .rdData(rdData),
    .pwmOut(pwmOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    #1 d = rdData;
    rdValid = 1'b0;
  endtask

  // sample 'cycles' cycles right after a start write; duties used period by period
  task automatic checkWave(input string req, input int n, input int p, input int nd,
                           input int d[4], input bit inv, input int cycles);
    int bad = 0;
    int badK = 0;
    logic got = 1'b0;
    logic want = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      int idx, c, du;
      logic e;
      @(negedge clk);
      idx = k / (n * (p + 2));
      c   = (k / n) % (p + 2);
      du  = d[(idx < nd) ? idx : nd - 1];
      e   = (c < du) ^ inv;
      if (pwmOut !== e && bad == 0) begin
        bad = 1; badK = k; got = pwmOut; want = e;
      end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: cycle %0d actual %0b expected %0b", req, badK, got, want);
    end
  endtask

  task automatic softReset();
    writeReg(3'd0, 32'h8);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readReg(3'd0, v); check("R1 ctrl", v, 0);
    readReg(3'd1, v); check("R1 stat", v, 0);
    readReg(3'd3, v); check("R1 duty", v, 0);
    readReg(3'd4, v); check("R1 period", v, 0);
    check("R1 out", {31'b0, pwmOut}, 0);
  endtask

  task automatic t_ctrlFields();
    logic [31:0] v;
    writeReg(3'd0, 32'hFFFF_FFF6);
    readReg(3'd0, v); check("R2 readback", v, 32'h03C7_FFF0);
    check("R8 idle inverted", {31'b0, pwmOut}, 1);
    writeReg(3'd0, 32'h0);
    readReg(3'd0, v); check("R2 cleared", v, 0);
    check("R8 idle normal", {31'b0, pwmOut}, 0);
  endtask

  task automatic t_fifoFill();
    logic [31:0] v;
    softReset();
    for (int i = 1; i <= 4; i++) begin
      writeReg(3'd3, 32'(i * 10));
      readReg(3'd1, v); check("R3 occupancy", v, 32'(i));
    end
    writeReg(3'd3, 32'd99);
    readReg(3'd1, v); check("R4 full drop", v, 32'h14);
    writeReg(3'd4, 32'd5);
    readReg(3'd1, v); check("R4 sticky", v, 32'h14);
    softReset();
    readReg(3'd1, v); check("R10 flush stat", v, 0);
    readReg(3'd4, v); check("R10 flush period", v, 0);
  endtask

  task automatic t_sequence();
    int d[4];
    softReset();
    writeReg(3'd4, 32'd3);
    writeReg(3'd3, 32'd2);
    writeReg(3'd3, 32'd5);
    writeReg(3'd3, 32'd0);
    writeReg(3'd0, 32'h1);
    d = '{2, 5, 0, 0};
    checkWave("R7 R6 R5 queued duties", 1, 3, 3, d, 1'b0, 25);
    writeReg(3'd0, 32'h0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R9 stopped level", {31'b0, pwmOut}, 0);
    end
    writeReg(3'd3, 32'd3);
    writeReg(3'd0, 32'h1);
    d = '{3, 3, 3, 3};
    checkWave("R9 restart R7 reuse", 1, 3, 1, d, 1'b0, 15);
  endtask

  task automatic t_prescale();
    int d[4];
    logic [31:0] v;
    softReset();
    writeReg(3'd4, 32'd1);
    writeReg(3'd3, 32'd1);
    writeReg(3'd0, 32'h1 | (32'd2 << 4));
    d = '{1, 1, 1, 1};
    checkWave("R5 divide by 3", 3, 1, 1, d, 1'b0, 27);
    readReg(3'd3, v); check("R11 duty readback", v, 1);
    readReg(3'd1, v); check("R7 popped", v, 0);
  endtask

  task automatic t_invert();
    int d[4];
    softReset();
    writeReg(3'd4, 32'd2);
    writeReg(3'd3, 32'd2);
    writeReg(3'd0, 32'h1 | (32'd1 << 4) | (32'd1 << 18));
    d = '{2, 2, 2, 2};
    checkWave("R8 inverted wave", 2, 2, 1, d, 1'b1, 16);
  endtask

  task automatic t_swrRun();
    logic [31:0] v;
    softReset();
    writeReg(3'd4, 32'd6);
    writeReg(3'd3, 32'd7);
    writeReg(3'd3, 32'd4);
    writeReg(3'd0, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 pre-check running", {31'b0, pwmOut}, 1);
    writeReg(3'd0, 32'h0004_0009);
    check("R10 output stopped", {31'b0, pwmOut}, 0);
    readReg(3'd0, v); check("R10 ctrl zero", v, 0);
    readReg(3'd1, v); check("R10 stat zero", v, 0);
    readReg(3'd3, v); check("R10 duty zero", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    softReset();
    writeReg(3'd4, 32'h0000_1234);
    writeReg(3'd2, 32'hFFFF_FFFF);
    writeReg(3'd5, 32'hFFFF_FFFF);
    readReg(3'd2, v); check("R11 word2 reads zero", v, 0);
    readReg(3'd6, v); check("R11 word6 reads zero", v, 0);
    readReg(3'd0, v); check("R11 ctrl untouched", v, 0);
    readReg(3'd1, v); check("R11 stat untouched", v, 0);
    readReg(3'd4, v); check("R11 period kept", v, 32'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ctrlFields();
    t_fifoFill();
    t_sequence();
    t_prescale();
    t_invert();
    t_swrRun();
    t_unmapped();
    check("R3 write ready", {31'b0, wrReady}, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule